// File: doc/BRIEF.md
# Page Write Sequencer with Status Polling

This block gathers single-byte load requests into a page buffer and then writes the page into a storage array as one timed operation. The first accepted load opens a page. Its address bits above the in-page offset fix which page is being filled. Further loads to that page are accepted until no load has arrived for a set number of cycles. That idle window is a retriggerable one-shot: every accepted load starts it again from zero.

When the window runs out, a programming phase of fixed length begins. During this phase the loaded bytes are moved into the array, and the positions that were never loaded keep their old contents. The phase has the same length whatever the number of bytes loaded.

A host can poll for completion. While a write cycle is open, a read of the most recently loaded address returns that byte with its most significant bit inverted. Once the busy flag drops, every read returns true data and a new page may be opened. Read data appears one cycle after the read request.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy` and `page_err` are 0 and every array location reads as 0x00.
- R2: A load request accepted while idle raises `busy` in the next cycle and opens the page given by address bits above bit 6 of that load.
- R3: Every accepted load restarts the idle counter; programming starts only after `LOAD_TIMEOUT` consecutive cycles with no accepted load.
- R4: Programming lasts `PROG_CYCLES` cycles whatever the number of bytes loaded, so `busy` falls exactly `LOAD_TIMEOUT + PROG_CYCLES` cycles after the last accepted load.
- R5: While `busy` is high, a read of the last loaded address returns the loaded byte with bit 7 inverted and bits 6..0 unchanged, on `rd_data` one cycle after `rd_req`.
- R6: After `busy` falls, a read of any loaded address returns the loaded byte unchanged on all bits.
- R7: A load during page loading whose address bits above bit 6 differ from the open page pulses `page_err` high for one cycle. It writes nothing and does not restart the idle counter.
- R8: Offsets of a page that were not loaded in a write cycle keep their previous contents after that cycle.
- R9: Load requests during the programming phase are ignored. They write nothing, raise no `page_err` and do not change the phase length.
- R10: A page holds 128 bytes at offsets 0 to 127 (address bits 6..0), and a load to every offset stores all 128 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Byte load request |
| ld_addr | input | ADDR_W | Byte load address |
| ld_data | input | DATA_W | Byte load data |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, valid one cycle after `rd_req` |
| busy | output | 1 | A write cycle (loading or programming) is open |
| page_err | output | 1 | One-cycle pulse on a load to a different page |

## Verification
The assertions assume that the load inputs are qualified strobes, each a single-cycle pulse, and that no reset arrives in the middle of a write cycle except at start-up. The bench keeps to this. It drives every load and read as a pulse one cycle wide, away from the clock edge. It resets only once, at the start. Within a page it spaces retriggering loads no more than `LOAD_TIMEOUT - 1` cycles apart, so the idle window is reopened on purpose and never ends by accident.

// File: rtl/wps_pkg.sv
package wps_pkg;
   typedef enum logic [1:0] {
      WPS_IDLE = 2'd0,
      WPS_LOAD = 2'd1,
      WPS_PROG = 2'd2
   } wps_state_e;
endpackage

// File: rtl/wps_oneshot.sv
// Retriggerable idle timer: kick clears it, expiry fires after TIMEOUT quiet cycles.
module wps_oneshot #(
   parameter int TIMEOUT = 7500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic kick,
   output logic expired
);
   localparam int TCW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("wps_oneshot: TIMEOUT must be at least 2");
   end

   logic [TCW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (kick)
         cnt <= '0;
      else if (run && cnt != TCW'(TIMEOUT - 1))
         cnt <= cnt + 1'b1;
   end

   assign expired = run && !kick && (cnt == TCW'(TIMEOUT - 1));
endmodule

// File: rtl/wps_page_buf.sv
// Page staging buffer with a per-byte loaded mask.
module wps_page_buf #(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clear,
   input  logic [PAGE_W-1:0] a_idx,
   output logic [DATA_W-1:0] a_data,
   output logic              a_loaded,
   input  logic [PAGE_W-1:0] b_idx,
   output logic [DATA_W-1:0] b_data
);
   localparam int PAGE_BYTES = 1 << PAGE_W;

   logic [DATA_W-1:0]     bytes [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] loaded;

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bytes[i]  <= '0;
            loaded[i] <= 1'b0;
         end else if (wr_en && wr_idx == PAGE_W'(i)) begin
            bytes[i]  <= wr_data;
            loaded[i] <= 1'b1;
         end else if (clear) begin
            loaded[i] <= 1'b0;
         end
      end
   end

   assign a_data   = bytes[a_idx];
   assign a_loaded = loaded[a_idx];
   assign b_data   = bytes[b_idx];
endmodule

// File: rtl/wps_array.sv
// Behavioural storage array: one write port, one combinational read port.
module wps_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W > 12) begin : g_bad_depth
      $error("wps_array: ADDR_W too large for a behavioural model");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
   import wps_pkg::*;
#(
   parameter int ADDR_W       = 10,
   parameter int DATA_W       = 8,
   parameter int PAGE_W       = 7,
   parameter int LOAD_TIMEOUT = 7500,
   parameter int PROG_CYCLES  = 300000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_req,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              page_err
);
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int HI_W       = ADDR_W - PAGE_W;
   localparam int PCW        = $clog2(PROG_CYCLES);

   if (HI_W < 1) begin : g_bad_addr
      $error("page_write_seq: ADDR_W must exceed PAGE_W");
   end
   if (PROG_CYCLES < PAGE_BYTES) begin : g_bad_prog
      $error("page_write_seq: PROG_CYCLES must cover one commit per page byte");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("page_write_seq: DATA_W must be at least 2");
   end

   wps_state_e        st;
   logic [HI_W-1:0]   page_hi;
   logic [PAGE_W-1:0] last_off;
   logic [PCW-1:0]    pcnt;

   logic [HI_W-1:0]   ld_hi;
   logic [PAGE_W-1:0] ld_off;
   logic              accept, mismatch, expired, prog_done;
   logic [PAGE_W-1:0] commit_idx;
   logic              commit_in_range, commit_loaded, commit_we;
   logic [DATA_W-1:0] commit_data, last_data, arr_q;
   logic              poll_hit;

   assign ld_hi    = ld_addr[ADDR_W-1:PAGE_W];
   assign ld_off   = ld_addr[PAGE_W-1:0];
   assign accept   = ld_req && ((st == WPS_IDLE) || (st == WPS_LOAD && ld_hi == page_hi));
   assign mismatch = ld_req && (st == WPS_LOAD) && (ld_hi != page_hi);
   assign prog_done = (st == WPS_PROG) && (pcnt == PCW'(PROG_CYCLES - 1));

   wps_oneshot #(.TIMEOUT(LOAD_TIMEOUT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st == WPS_LOAD),
      .kick    (accept),
      .expired (expired)
   );

   assign commit_idx      = pcnt[PAGE_W-1:0];
   assign commit_in_range = int'(pcnt) < PAGE_BYTES;

   wps_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (accept),
      .wr_idx   (ld_off),
      .wr_data  (ld_data),
      .clear    (prog_done),
      .a_idx    (commit_idx),
      .a_data   (commit_data),
      .a_loaded (commit_loaded),
      .b_idx    (last_off),
      .b_data   (last_data)
   );

   assign commit_we = (st == WPS_PROG) && commit_in_range && commit_loaded;

   wps_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit_we),
      .waddr ({page_hi, commit_idx}),
      .wdata (commit_data),
      .raddr (rd_addr),
      .rdata (arr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= WPS_IDLE;
         page_hi  <= '0;
         last_off <= '0;
         pcnt     <= '0;
         page_err <= 1'b0;
      end else begin
         page_err <= mismatch;
         case (st)
            WPS_IDLE: begin
               if (accept) begin
                  st       <= WPS_LOAD;
                  page_hi  <= ld_hi;
                  last_off <= ld_off;
               end
            end
            WPS_LOAD: begin
               if (accept) begin
                  last_off <= ld_off;
               end else if (expired) begin
                  st   <= WPS_PROG;
                  pcnt <= '0;
               end
            end
            WPS_PROG: begin
               if (prog_done) st <= WPS_IDLE;
               else           pcnt <= pcnt + 1'b1;
            end
            default: st <= WPS_IDLE;
         endcase
      end
   end

   assign poll_hit = (st != WPS_IDLE) && (rd_addr == {page_hi, last_off});

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_req)
         rd_data <= poll_hit ? {~last_data[DATA_W-1], last_data[DATA_W-2:0]} : arr_q;
   end

   assign busy = (st != WPS_IDLE);
endmodule

// File: rtl/page_write_seq_chk.sv
module page_write_seq_chk
   import wps_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       ld_req,
   input logic       busy,
   input logic       page_err,
   input wps_state_e st
);
   // R2: a load seen while idle opens a write cycle
   a_r2_load_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req && st == WPS_IDLE) |=> busy);

   // R3: programming is entered only from loading, after a cycle without a load
   a_r3_quiet_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WPS_PROG && $past(st) != WPS_PROG) |-> ($past(st) == WPS_LOAD && !$past(ld_req)));

   // R4: a write cycle always closes out of the programming phase
   a_r4_close_from_prog: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(st) == WPS_PROG);

   // R7: a page error only follows a load made while loading
   a_r7_err_source: assert property (@(posedge clk) disable iff (!rst_n)
      page_err |-> ($past(ld_req) && $past(st) == WPS_LOAD));

   // R9: loads during programming never raise a page error
   a_r9_quiet_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WPS_PROG) |=> !page_err);
endmodule

bind page_write_seq page_write_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_req   (ld_req),
   .busy     (busy),
   .page_err (page_err),
   .st       (st)
);

// File: tb/page_write_seq_tb.sv
module page_write_seq_tb;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int T  = 20;
   localparam int P  = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_req = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [DW-1:0] ld_data = '0;
   logic          rd_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          busy, page_err;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int last_ld = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   page_write_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(7),
                    .LOAD_TIMEOUT(T), .PROG_CYCLES(P)) u_dut (
      .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_addr(ld_addr), .ld_data(ld_data),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .page_err(page_err));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a negedge; load sampled at the next posedge
   task automatic load(input int a, input int d, input bit counts);
      ld_req = 1'b1; ld_addr = AW'(a); ld_data = DW'(d);
      @(negedge clk);
      ld_req = 1'b0;
      if (counts) last_ld = cyc;
   endtask

   task automatic rd(input int a, output int d);
      rd_req = 1'b1; rd_addr = AW'(a);
      @(negedge clk);
      rd_req = 1'b0;
      d = int'(rd_data);
   endtask

   task automatic wait_idle(input string req);
      while (busy) @(negedge clk);
      chk(req, cyc - last_ld, T + P);
   endtask

   task automatic wait_until(input int rel);
      while (cyc - last_ld < rel) @(negedge clk);
   endtask

   task automatic t_reset();
      int d;
      chk("R1 busy", int'(busy), 0);
      chk("R1 page_err", int'(page_err), 0);
      rd(12'h085, d); chk("R1 array zero", d, 0);
   endtask

   task automatic t_single();
      int d;
      load(12'h085, 8'h3C, 1'b1);
      chk("R2 busy after load", int'(busy), 1);
      rd(12'h085, d); chk("R5 poll while loading", d, 8'hBC);
      wait_until(T + 5);
      rd(12'h085, d); chk("R5 poll while programming", d, 8'hBC);
      wait_idle("R4 single byte duration");
      rd(12'h085, d); chk("R6 true data", d, 8'h3C);
      rd(12'h086, d); chk("R8 neighbour unchanged", d, 0);
   endtask

   task automatic t_bit7_set();
      int d;
      load(12'h1A0, 8'hF1, 1'b1);
      rd(12'h1A0, d); chk("R5 poll msb set", d, 8'h71);
      wait_idle("R4 duration");
      rd(12'h1A0, d); chk("R6 msb set stored", d, 8'hF1);
   endtask

   task automatic t_retrigger();
      int d;
      for (int i = 0; i < 4; i++) begin
         load(12'h200 + i, 8'h10 + i, 1'b1);
         if (i < 3) repeat (T - 2) @(negedge clk);
      end
      chk("R3 still busy after spaced loads", int'(busy), 1);
      wait_idle("R3 R4 duration from last load");
      for (int i = 0; i < 4; i++) begin
         rd(12'h200 + i, d); chk("R6 retrigger bytes", d, 8'h10 + i);
      end
   endtask

   task automatic t_mismatch();
      int d;
      load(12'h280, 8'h11, 1'b1);
      repeat (5) @(negedge clk);
      load(12'h300, 8'h22, 1'b0);
      chk("R7 page_err pulse", int'(page_err), 1);
      @(negedge clk);
      chk("R7 page_err one cycle", int'(page_err), 0);
      wait_idle("R7 no retrigger");
      rd(12'h300, d); chk("R7 foreign byte ignored", d, 0);
      rd(12'h280, d); chk("R7 page byte stored", d, 8'h11);
   endtask

   task automatic t_prog_ignore();
      int d;
      load(12'h040, 8'h55, 1'b1);
      wait_until(T + 3);
      load(12'h041, 8'h66, 1'b0);
      chk("R9 no page_err", int'(page_err), 0);
      wait_idle("R9 duration unchanged");
      rd(12'h041, d); chk("R9 load ignored", d, 0);
      rd(12'h040, d); chk("R9 earlier byte", d, 8'h55);
   endtask

   task automatic t_full_page();
      int d;
      for (int i = 0; i < 128; i++) load(12'h380 + i, (i ^ 8'h5A) & 8'hFF, 1'b1);
      wait_idle("R10 full page duration");
      for (int i = 0; i < 128; i++) begin
         rd(12'h380 + i, d); chk("R10 full page byte", d, (i ^ 8'h5A) & 8'hFF);
      end
      load(12'h385, 8'hEE, 1'b1);
      wait_idle("R4 rewrite duration");
      rd(12'h385, d); chk("R6 rewritten byte", d, 8'hEE);
      rd(12'h384, d); chk("R8 offset 4 kept", d, 4 ^ 8'h5A);
      rd(12'h386, d); chk("R8 offset 6 kept", d, 6 ^ 8'h5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_bit7_set();
      t_retrigger();
      t_mismatch();
      t_prog_ignore();
      t_full_page();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule